// File: doc/BRIEF.md
# Prescaled Cascaded Clock Division Path

This block models the division path of one clock distribution channel, running entirely in the source clock domain. Every source clock cycle is one input event. An optional prescaler with a ratio of 2 to 6 divides these events first. Its output then passes through a chain of channel divider stages, one or two depending on a parameter. Each stage divides by 2 to 32 or is bypassed (ratio 1). The divided clock leaves the block as a one-cycle strobe, `tick_o`, raised once per output period. The period is measured in source cycles.

A direct-route option sends every source event straight to the output, for a total division of 1, and ignores the prescaler and stage settings. Direct routing is honoured only when the prescaler path is the selected source. If it is requested while the prescaler is skipped, the block raises an error flag and keeps the normal divider path. The block also reports the total ratio it is applying as an integer, so the surrounding logic or a bench can compare it with the measured strobe period. A sync input clears the prescaler and all stages together, so every divider in the cascade starts from the same phase.

Top module: `clkdist_path`

## Requirements
- R1: With `pre_skip_i`=0 and direct routing off, `tick_o` repeats every P×S source cycles. P is the prescaler ratio and S is the product of the stage ratios.
- R2: With `pre_skip_i`=1, the prescaler is left out and the period equals S alone. With every stage also bypassed the period is 1, a strobe on every cycle.
- R3: In the two-stage build, the channel ratio is the product of both stage ratios. A stage whose bypass flag is 1 counts as ratio 1.
- R4: With `direct_i`=1 and `pre_skip_i`=0, `tick_o` is high on every cycle after sync, `ratio_o` is 1, and all ratio and bypass settings have no effect.
- R5: With `direct_i`=1 and `pre_skip_i`=1, `route_err_o` is 1 and the output follows the normal divider path. Otherwise `route_err_o` is 0. The flag is registered and updates one cycle after its inputs.
- R6: `ratio_o` holds the total ratio applied: 1 for direct routing, otherwise P×S. It updates one clock after the settings change.
- R7: Prescaler ratio codes below 2 act as 2 and codes above 6 act as 6. Stage ratio codes below 2 act as 2 and codes above 32 act as 32.
- R8: While `sync_i` is high, `tick_o` is low on the following cycle. Counting the first cycle after sync falls as cycle 0, the first strobe appears at cycle T and the next at cycle 2T, where T is the total ratio.
- R9: After reset, `tick_o`, `route_err_o` and `ratio_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; each cycle is one input event |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Clears prescaler and all stage counters together |
| pre_skip_i | input | 1 | Path mode: 0 uses the prescaler, 1 skips it |
| pre_ratio_i | input | 3 | Prescaler ratio code, effective range 2..6 |
| stg_a_bypass_i | input | 1 | First stage bypass (ratio 1) |
| stg_a_ratio_i | input | 6 | First stage ratio code, effective range 2..32 |
| stg_b_bypass_i | input | 1 | Second stage bypass (ratio 1) |
| stg_b_ratio_i | input | 6 | Second stage ratio code, effective range 2..32 |
| direct_i | input | 1 | Request direct routing of source events |
| tick_o | output | 1 | Divided clock strobe, one cycle per output period |
| ratio_o | output | 13 | Total division ratio being applied |
| route_err_o | output | 1 | Direct routing requested with the prescaler skipped |

## Verification
A vector table covers several path shapes:
- the prescaler alone;
- the prescaler with one stage;
- the prescaler with both stages at their maximum (6144);
- stages alone, with and without bypass;
- the fully bypassed ratio-1 case;
- legal and illegal direct routing;
- out-of-range ratio codes.

Each vector measures both the offset of the first strobe after sync and the interval to the second. The offset separates a cascade that was not cleared together from one that was. The interval separates a sum of ratios, or a skipped stage, from the correct product. Directed cases cover the reset values, the silence of the strobe while sync is held, and the one-cycle update delay of `ratio_o`.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

    localparam int PRE_MIN = 2;
    localparam int PRE_MAX = 6;
    localparam int STG_MIN = 2;
    localparam int STG_MAX = 32;
    localparam int PRE_W   = $clog2(PRE_MAX + 2);
    localparam int STG_W   = $clog2(STG_MAX + 1);

    typedef struct packed {
        logic             bypass;
        logic [STG_W-1:0] ratio;
    } stage_cfg_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int max_total(input int stages);
        int p;
        p = PRE_MAX;
        for (int i = 0; i < stages; i++) p = p * STG_MAX;
        return p;
    endfunction

endpackage

// File: rtl/clkdist_tick_div.sv
module clkdist_tick_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             in_tick_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             out_tick_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             at_end;

    assign last   = ratio_i - CNT_W'(1);
    assign at_end = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || sync_i || bypass_i) begin
            cnt <= '0;
        end else if (in_tick_i) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + CNT_W'(1);
        end
    end

    assign out_tick_o = in_tick_i && (bypass_i || at_end);

    // R8: sync leaves the counter at phase zero
    assert_sync_zero_R8: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (cnt == '0));

    // R1: a dividing stage (ratio >= 2) never fires on two successive cycles
    assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (rst)
        (out_tick_o && !bypass_i) |=> !(out_tick_o && !bypass_i));

endmodule

// File: rtl/clkdist_cfg.sv
module clkdist_cfg
    import clkdist_pkg::*;
#(
    parameter int NUM_STAGES = 2,
    parameter int RATIO_W    = 13
) (
    input  logic                  pre_skip_i,
    input  logic [PRE_W-1:0]      pre_ratio_i,
    input  stage_cfg_t            stg_raw_i [NUM_STAGES],
    input  logic                  direct_i,
    output logic [PRE_W-1:0]      pre_eff_o,
    output logic [STG_W-1:0]      stg_eff_o [NUM_STAGES],
    output logic                  direct_ok_o,
    output logic                  err_o,
    output logic [RATIO_W-1:0]    total_o
);
    int prod;

    assign pre_eff_o   = PRE_W'(clamp_int(int'(pre_ratio_i), PRE_MIN, PRE_MAX));
    assign direct_ok_o = direct_i && !pre_skip_i;
    assign err_o       = direct_i && pre_skip_i;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage_eff
        assign stg_eff_o[s] = STG_W'(clamp_int(int'(stg_raw_i[s].ratio), STG_MIN, STG_MAX));
    end

    always_comb begin
        prod = pre_skip_i ? 1 : int'(pre_eff_o);
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (!stg_raw_i[s].bypass) prod = prod * int'(stg_eff_o[s]);
        end
        total_o = direct_ok_o ? RATIO_W'(1) : RATIO_W'(prod);
    end

endmodule

// File: rtl/clkdist_path.sv
module clkdist_path
    import clkdist_pkg::*;
#(
    parameter int NUM_STAGES = 2,
    parameter int RATIO_W    = $clog2(max_total(NUM_STAGES) + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_i,
    input  logic               pre_skip_i,
    input  logic [PRE_W-1:0]   pre_ratio_i,
    input  logic               stg_a_bypass_i,
    input  logic [STG_W-1:0]   stg_a_ratio_i,
    input  logic               stg_b_bypass_i,
    input  logic [STG_W-1:0]   stg_b_ratio_i,
    input  logic               direct_i,
    output logic               tick_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               route_err_o
);
    stage_cfg_t         cfg_all [2];
    stage_cfg_t         cfg_used [NUM_STAGES];
    logic [PRE_W-1:0]   pre_eff;
    logic [STG_W-1:0]   stg_eff [NUM_STAGES];
    logic               direct_ok;
    logic               err_now;
    logic [RATIO_W-1:0] total_now;
    logic               src_tick;
    logic               chain [NUM_STAGES+1];
    logic               fire;

    assign cfg_all[0] = '{bypass: stg_a_bypass_i, ratio: stg_a_ratio_i};
    assign cfg_all[1] = '{bypass: stg_b_bypass_i, ratio: stg_b_ratio_i};

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cfg_pick
        assign cfg_used[s] = cfg_all[s];
    end

    clkdist_cfg #(
        .NUM_STAGES (NUM_STAGES),
        .RATIO_W    (RATIO_W)
    ) u_cfg (
        .pre_skip_i  (pre_skip_i),
        .pre_ratio_i (pre_ratio_i),
        .stg_raw_i   (cfg_used),
        .direct_i    (direct_i),
        .pre_eff_o   (pre_eff),
        .stg_eff_o   (stg_eff),
        .direct_ok_o (direct_ok),
        .err_o       (err_now),
        .total_o     (total_now)
    );

    assign src_tick = !sync_i;

    clkdist_tick_div #(
        .CNT_W (PRE_W)
    ) u_pre (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .in_tick_i  (src_tick),
        .bypass_i   (pre_skip_i),
        .ratio_i    (pre_eff),
        .out_tick_o (chain[0])
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        clkdist_tick_div #(
            .CNT_W (STG_W)
        ) u_div (
            .clk        (clk),
            .rst        (rst),
            .sync_i     (sync_i),
            .in_tick_i  (chain[s]),
            .bypass_i   (cfg_used[s].bypass),
            .ratio_i    (stg_eff[s]),
            .out_tick_o (chain[s+1])
        );
    end

    assign fire = direct_ok ? src_tick : chain[NUM_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_o      <= 1'b0;
            ratio_o     <= '0;
            route_err_o <= 1'b0;
        end else begin
            tick_o      <= fire;
            ratio_o     <= total_now;
            route_err_o <= err_now;
        end
    end

    // R4: legal direct routing strobes on every cycle outside sync
    assert_direct_every_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (direct_i && !pre_skip_i && !sync_i) |=> tick_o);

    // R4: legal direct routing reports a ratio of one
    assert_direct_ratio_R4: assert property (@(posedge clk) disable iff (rst)
        (direct_i && !pre_skip_i) |=> (ratio_o == RATIO_W'(1)));

    // R5: error flag tracks the illegal request one cycle later
    assert_route_err_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (route_err_o == $past(direct_i && pre_skip_i)));

    // R8: no strobe follows a sync cycle
    assert_sync_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> !tick_o);

    // R6: once running, the reported ratio is never zero
    assert_ratio_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ratio_o != '0));

endmodule

// File: tb/clkdist_path_tb.sv
module clkdist_path_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        sync_i;
    logic        pre_skip_i;
    logic [2:0]  pre_ratio_i;
    logic        stg_a_bypass_i;
    logic [5:0]  stg_a_ratio_i;
    logic        stg_b_bypass_i;
    logic [5:0]  stg_b_ratio_i;
    logic        direct_i;
    logic        tick_o;
    logic [12:0] ratio_o;
    logic        route_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clkdist_path u_dut (
        .clk            (clk),
        .rst            (rst),
        .sync_i         (sync_i),
        .pre_skip_i     (pre_skip_i),
        .pre_ratio_i    (pre_ratio_i),
        .stg_a_bypass_i (stg_a_bypass_i),
        .stg_a_ratio_i  (stg_a_ratio_i),
        .stg_b_bypass_i (stg_b_bypass_i),
        .stg_b_ratio_i  (stg_b_ratio_i),
        .direct_i       (direct_i),
        .tick_o         (tick_o),
        .ratio_o        (ratio_o),
        .route_err_o    (route_err_o)
    );

    typedef struct packed {
        logic        skip;
        logic [2:0]  pre;
        logic        a_byp;
        logic [5:0]  a;
        logic        b_byp;
        logic [5:0]  b;
        logic        dir;
        logic [12:0] ratio;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd2, 1'b1, 6'd9,  1'b1, 6'd9,  1'b0, 13'd2,    1'b0, 4'd1}, // R1 prescaler only
        '{1'b0, 3'd3, 1'b0, 6'd5,  1'b1, 6'd9,  1'b0, 13'd15,   1'b0, 4'd1}, // R1 prescaler x stage
        '{1'b0, 3'd6, 1'b0, 6'd32, 1'b0, 6'd32, 1'b0, 13'd6144, 1'b0, 4'd3}, // R3 full cascade
        '{1'b1, 3'd4, 1'b0, 6'd7,  1'b1, 6'd3,  1'b0, 13'd7,    1'b0, 4'd2}, // R2 no prescaler
        '{1'b1, 3'd4, 1'b0, 6'd3,  1'b0, 6'd4,  1'b0, 13'd12,   1'b0, 4'd3}, // R3 two stages
        '{1'b1, 3'd5, 1'b1, 6'd3,  1'b1, 6'd4,  1'b0, 13'd1,    1'b0, 4'd2}, // R2 all bypassed
        '{1'b1, 3'd5, 1'b1, 6'd3,  1'b0, 6'd9,  1'b0, 13'd9,    1'b0, 4'd3}, // R3 first bypassed
        '{1'b0, 3'd4, 1'b0, 6'd5,  1'b0, 6'd0,  1'b1, 13'd1,    1'b0, 4'd4}, // R4 legal direct
        '{1'b1, 3'd4, 1'b0, 6'd4,  1'b1, 6'd7,  1'b1, 13'd4,    1'b1, 4'd5}, // R5 illegal direct
        '{1'b0, 3'd7, 1'b0, 6'd40, 1'b0, 6'd1,  1'b0, 13'd384,  1'b0, 4'd7}, // R7 clamp high/low
        '{1'b0, 3'd0, 1'b0, 6'd0,  1'b1, 6'd63, 1'b0, 13'd4,    1'b0, 4'd7}  // R7 clamp zero codes
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pre_skip_i     = v.skip;
        pre_ratio_i    = v.pre;
        stg_a_bypass_i = v.a_byp;
        stg_a_ratio_i  = v.a;
        stg_b_bypass_i = v.b_byp;
        stg_b_ratio_i  = v.b;
        direct_i       = v.dir;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        int first;
        int second;
        tag    = $sformatf("R%0d", v.req);
        first  = -1;
        second = -1;
        @(negedge clk);
        apply(v);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        chk(tag, "ratio_o", int'(ratio_o), int'(v.ratio));
        chk(tag, "route_err_o", int'(route_err_o), int'(v.err));
        for (int k = 0; k < 2 * int'(v.ratio) + 8 && second < 0; k++) begin
            if (k > 0) @(negedge clk);
            if (tick_o) begin
                if (first < 0) first = k;
                else           second = k;
            end
        end
        chk({tag, "/R8"}, "first strobe cycle", first, int'(v.ratio));
        chk(tag, "strobe interval", second - first, int'(v.ratio));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen;
        rst    = 1'b1;
        sync_i = 1'b0;
        apply(VEC[1]);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "tick_o", int'(tick_o), 0);
        chk("R9", "route_err_o", int'(route_err_o), 0);
        chk("R9", "ratio_o", int'(ratio_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: strobe stays low while sync is held
        @(negedge clk);
        apply(VEC[0]);
        sync_i = 1'b1;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        chk("R8", "strobes during sync", seen, 0);
        sync_i = 1'b0;

        // R6: ratio_o follows a settings change one clock later
        run_vec(VEC[1]);
        apply(VEC[3]);
        chk("R6", "ratio_o before edge", int'(ratio_o), 15);
        @(negedge clk);
        chk("R6", "ratio_o after edge", int'(ratio_o), 7);

        // R4: legal direct routing ignores the stage settings
        apply(VEC[7]);
        stg_a_ratio_i = 6'd17;
        stg_b_bypass_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "tick_o direct", int'(tick_o), 1);
        chk("R4", "ratio_o direct", int'(ratio_o), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule